// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM with Posted Write

This block is a synthesizable behavioural model of a pipelined static RAM that moves two data words per operation over a double-rate data path. A command is taken on a rising clock edge when the active-low load strobe is low. The read/write select then chooses the operation. Each operation covers the addressed word and its partner, which differs only in address bit 0. The double-rate interface is modelled as two beat slots per clock cycle. The rising-edge beat and the falling-edge beat of a write arrive together on two input buses. The two beats of a read leave on two output buses, and each output bus has its own valid flag.

A write is not placed in the array straight away. Its row address, data and lane enables are parked in a posted-write register. They are committed to the array only when the next write is accepted, and at that moment the new write takes the parked slot. A read whose row matches the parked write is served through a lane-by-lane merge of the parked bytes over the array bytes. A read therefore always sees the most recent data, even in the cycle right after the write.

Software sees the block as a memory. The surrounding controller must leave one idle cycle between a read and a following write. A write may be followed by a read with no gap.

Top module: `b2_ddr_sram`

## Requirements
- R1: While `ld_n` is high, no operation takes place, whatever the values on `rw_n`, `addr` and the data and mask inputs. No valid beat is produced and no array or pending content changes.
- R2: A read at address A returns two words. `rd_first` carries the word at A. `rd_second` carries the word at A with bit 0 inverted. Both words share address bits [AW-1:1].
- R3: A read accepted at rising edge t sets `rd_first_vld` for the cycle that follows edge t+1 and `rd_second_vld` for the cycle that follows edge t+2. A read may be accepted on every cycle, and each read yields exactly one pulse on each flag.
- R4: A write at address A places the `wd_rise` beat at word A and the `wd_fall` beat at word A with bit 0 inverted. The write is held pending and reaches the array only when the next write is accepted.
- R5: While a write is pending, a read to the same row returns the pending bytes without any wait cycle. Reads to other rows return array contents.
- R6: Mask bit l of `wm_rise_n` or `wm_fall_n` governs bits [l*LW+LW-1 : l*LW] of its own beat, where LW = DW/NL. A low bit writes that lane. A high bit keeps the earlier contents, and this holds both on commit and in the read merge.
- R7: A low `rst_n` immediately clears both read-valid flags and discards the pending write without writing it to the array. After `rst_n` rises, commands are accepted from the third rising edge on.
- R8: A write issued in the cycle immediately after a read breaks the protocol and is flagged. A write that follows a read after one idle cycle is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; both beat slots belong to one period |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| ld_n | input | 1 | Active-low load; low starts an operation |
| rw_n | input | 1 | High selects read, low selects write |
| addr | input | AW | Word address of the first beat |
| wd_rise | input | DW | Write data of the rising-edge beat |
| wm_rise_n | input | NL | Active-low lane write mask for the rising-edge beat |
| wd_fall | input | DW | Write data of the falling-edge beat |
| wm_fall_n | input | NL | Active-low lane write mask for the falling-edge beat |
| rd_first | output | DW | First read beat (word at addr) |
| rd_first_vld | output | 1 | Marks a valid first beat |
| rd_second | output | DW | Second read beat (partner word) |
| rd_second_vld | output | 1 | Marks a valid second beat |

## Verification
Every operation is placed in the reference model at the edge that accepts it. The first read beat of a command is due one full cycle after that edge, and the second beat one cycle later still. The bench keeps these two delays as a two-stage expectation pipeline that shifts on each rising edge. It compares both outputs and both flags at the next falling edge, so every result is checked in exactly the cycle it is due. Writes have no direct output. Their effect is checked through later reads, some taken while the write is still pending and some after a further write has committed it, and across a reset that must discard a pending write.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;

  function automatic cmd_e cmd_decode(input logic ld_n, input logic rw_n);
    if (ld_n)      return CMD_NONE;
    else if (rw_n) return CMD_RD;
    else           return CMD_WR;
  endfunction

endpackage

// File: rtl/b2s_array.sv
// Row-organised storage: one row holds both words of a burst pair, so a
// pending pair commits in a single cycle with per-lane enables.
module b2s_array #(
  parameter int RW = 5,
  parameter int DW = 18,
  parameter int NL = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RW-1:0]     wrow,
  input  logic [2*DW-1:0]   wpair,
  input  logic [2*NL-1:0]   wen,
  input  logic [RW-1:0]     rrow,
  output logic [2*DW-1:0]   rpair
);
  localparam int ROWS = 1 << RW;
  localparam int LW   = DW / NL;
  localparam int NE   = 2 * NL;

  logic [2*DW-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < NE; i++) begin
        if (wen[i]) mem_q[wrow][i*LW +: LW] <= wpair[i*LW +: LW];
      end
    end
  end

  assign rpair = mem_q[rrow];

endmodule

// File: rtl/b2s_posted.sv
// Posted-write register with row compare and lane-wise read merge.
module b2s_posted #(
  parameter int RW = 5,
  parameter int DW = 18,
  parameter int NL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [RW-1:0]     wr_row,
  input  logic [2*DW-1:0]   wr_pair,
  input  logic [2*NL-1:0]   wr_en,
  input  logic              rd_go,
  input  logic [RW-1:0]     rd_row,
  input  logic [2*DW-1:0]   arr_pair,
  output logic              pend_vld,
  output logic [RW-1:0]     pend_row,
  output logic [2*DW-1:0]   pend_pair,
  output logic [2*NL-1:0]   pend_en,
  output logic [2*DW-1:0]   rd_pair
);
  localparam int LW = DW / NL;
  localparam int NE = 2 * NL;

  logic vld_d;
  logic hit;

  always_comb vld_d = pend_vld | wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_vld <= 1'b0;
    else        pend_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      pend_row  <= wr_row;
      pend_pair <= wr_pair;
      pend_en   <= wr_en;
    end
  end

  // Compare only matters for a read with a write parked.
  always_comb hit = rd_go && pend_vld && (pend_row == rd_row);

  for (genvar i = 0; i < NE; i++) begin : g_lane
    assign rd_pair[i*LW +: LW] = (hit && pend_en[i]) ? pend_pair[i*LW +: LW]
                                                     : arr_pair[i*LW +: LW];
  end

endmodule

// File: rtl/b2s_rdpipe.sv
// Read launch pipeline: first beat one cycle after capture, second beat one later.
module b2s_rdpipe #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  output logic [DW-1:0] first,
  output logic          first_vld,
  output logic [DW-1:0] second,
  output logic          second_vld
);
  logic          cap_vld;
  logic [DW-1:0] cap_w0, cap_w1, hold_w1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld    <= 1'b0;
      first_vld  <= 1'b0;
      second_vld <= 1'b0;
    end else begin
      cap_vld    <= go;
      first_vld  <= cap_vld;
      second_vld <= first_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      cap_w0 <= w0;
      cap_w1 <= w1;
    end
    if (cap_vld) begin
      first   <= cap_w0;
      hold_w1 <= cap_w1;
    end
    if (first_vld) second <= hold_w1;
  end

endmodule

// File: rtl/b2_ddr_sram.sv
module b2_ddr_sram
  import b2s_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd_rise,
  input  logic [NL-1:0] wm_rise_n,
  input  logic [DW-1:0] wd_fall,
  input  logic [NL-1:0] wm_fall_n,
  output logic [DW-1:0] rd_first,
  output logic          rd_first_vld,
  output logic [DW-1:0] rd_second,
  output logic          rd_second_vld
);
  localparam int RW = AW - 1;
  localparam int PW = 2 * DW;
  localparam int PE = 2 * NL;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  cmd_e          cmd;
  logic          rd_go, wr_go, lo;
  logic [RW-1:0] row, pend_row;
  logic [PW-1:0] wr_pair, pend_pair, arr_pair, rd_pair;
  logic [PE-1:0] wr_en, pend_en;
  logic          pend_vld;
  logic [DW-1:0] word0, word1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    cmd   = cmd_decode(ld_n, rw_n);
    rd_go = rst_core_n && (cmd == CMD_RD);
    wr_go = rst_core_n && (cmd == CMD_WR);
  end

  assign lo  = addr[0];
  assign row = addr[AW-1:1];

  // Steer beats into word slots: slot index = address bit 0 of that word.
  always_comb begin
    if (lo) begin
      wr_pair = {wd_rise, wd_fall};
      wr_en   = {~wm_rise_n, ~wm_fall_n};
    end else begin
      wr_pair = {wd_fall, wd_rise};
      wr_en   = {~wm_fall_n, ~wm_rise_n};
    end
  end

  b2s_array #(.RW(RW), .DW(DW), .NL(NL)) u_array (
    .clk   (clk),
    .we    (wr_go && pend_vld),
    .wrow  (pend_row),
    .wpair (pend_pair),
    .wen   (pend_en),
    .rrow  (row),
    .rpair (arr_pair)
  );

  b2s_posted #(.RW(RW), .DW(DW), .NL(NL)) u_posted (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_go     (wr_go),
    .wr_row    (row),
    .wr_pair   (wr_pair),
    .wr_en     (wr_en),
    .rd_go     (rd_go),
    .rd_row    (row),
    .arr_pair  (arr_pair),
    .pend_vld  (pend_vld),
    .pend_row  (pend_row),
    .pend_pair (pend_pair),
    .pend_en   (pend_en),
    .rd_pair   (rd_pair)
  );

  assign word0 = lo ? rd_pair[DW +: DW] : rd_pair[0 +: DW];
  assign word1 = lo ? rd_pair[0 +: DW]  : rd_pair[DW +: DW];

  b2s_rdpipe #(.DW(DW)) u_rdpipe (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .go         (rd_go),
    .w0         (word0),
    .w1         (word1),
    .first      (rd_first),
    .first_vld  (rd_first_vld),
    .second     (rd_second),
    .second_vld (rd_second_vld)
  );

endmodule

// File: rtl/b2_ddr_sram_chk.sv
module b2_ddr_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic rw_n,
  input logic rd_first_vld,
  input logic rd_second_vld
);
  logic rd_d1, rd_d2, idle_d1, idle_d2, fv_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1 <= 1'b0; rd_d2 <= 1'b0;
      idle_d1 <= 1'b0; idle_d2 <= 1'b0;
      fv_d1 <= 1'b0;
    end else begin
      rd_d1   <= !ld_n && rw_n;
      rd_d2   <= rd_d1;
      idle_d1 <= ld_n;
      idle_d2 <= idle_d1;
      fv_d1   <= rd_first_vld;
    end
  end

  // R3: read accepted two samples ago must show its first beat now
  a_r3_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d2 |-> rd_first_vld);
  // R3: first beat is always followed by the second beat
  a_r3_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first_vld |=> rd_second_vld);
  // R2: second beat never appears without a first beat before it
  a_r2_second_paired: assert property (@(posedge clk) disable iff (!rst_n)
    rd_second_vld |-> fv_d1);
  // R1: an idle slot yields no first beat
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idle_d2 |-> !rd_first_vld);
  // R8: no write directly after a read
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d1 |-> !(!ld_n && !rw_n));

endmodule

bind b2_ddr_sram b2_ddr_sram_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .ld_n          (ld_n),
  .rw_n          (rw_n),
  .rd_first_vld  (rd_first_vld),
  .rd_second_vld (rd_second_vld)
);

// File: tb/b2_ddr_sram_tb.sv
`timescale 1ns/1ps
module b2_ddr_sram_tb;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int NL = 2;
  localparam int LW = DW / NL;
  localparam int WORDS = 1 << AW;

  logic          clk, rst_n, ld_n, rw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd_rise, wd_fall, rd_first, rd_second;
  logic [NL-1:0] wm_rise_n, wm_fall_n;
  logic          rd_first_vld, rd_second_vld;

  int n_chk, n_fail;
  bit done;

  // reference state
  logic [DW-1:0] rmem [WORDS];
  logic          p_vld;
  int            p_row;
  logic [DW-1:0] p_w [2];
  logic [NL-1:0] p_e [2];

  // expectation pipeline
  logic          pa_v, pb_v, ef_v, es_v;
  logic [DW-1:0] pa_d0, pa_d1, pb_d1, ef_d, es_d;
  string         pa_t, pb_t, ef_t, es_t;

  b2_ddr_sram #(.AW(AW), .DW(DW), .NL(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw_n(rw_n), .addr(addr),
    .wd_rise(wd_rise), .wm_rise_n(wm_rise_n), .wd_fall(wd_fall), .wm_fall_n(wm_fall_n),
    .rd_first(rd_first), .rd_first_vld(rd_first_vld),
    .rd_second(rd_second), .rd_second_vld(rd_second_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_rd(input int a);
    logic [DW-1:0] v;
    int w;
    w = a & 1;
    v = rmem[a];
    if (p_vld && p_row == (a >> 1))
      for (int l = 0; l < NL; l++)
        if (p_e[w][l]) v[l*LW +: LW] = p_w[w][l*LW +: LW];
    return v;
  endfunction

  task automatic ref_wr(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    int lo;
    if (p_vld)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < NL; l++)
          if (p_e[w][l]) rmem[p_row*2 + w][l*LW +: LW] = p_w[w][l*LW +: LW];
    lo = a & 1;
    p_vld = 1'b1;
    p_row = a >> 1;
    p_w[lo] = d0;     p_e[lo] = ~m0;
    p_w[lo ^ 1] = d1; p_e[lo ^ 1] = ~m1;
  endtask

  task automatic step(input logic l, input logic rw, input int a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [NL-1:0] m0, input logic [NL-1:0] m1, input string tag);
    logic [DW-1:0] e0, e1;
    logic is_rd, is_wr;
    ld_n = l; rw_n = rw; addr = a[AW-1:0];
    wd_rise = d0; wd_fall = d1; wm_rise_n = m0; wm_fall_n = m1;
    is_rd = !l && rw;
    is_wr = !l && !rw;
    e0 = ref_rd(a);
    e1 = ref_rd(a ^ 1);
    @(posedge clk);
    if (is_wr) ref_wr(a, d0, d1, m0, m1);
    es_v = pb_v; es_d = pb_d1; es_t = pb_t;
    pb_v = pa_v; pb_d1 = pa_d1; pb_t = pa_t;
    ef_v = pa_v; ef_d = pa_d0; ef_t = pa_t;
    pa_v = is_rd; pa_d0 = e0; pa_d1 = e1; pa_t = tag;
    @(negedge clk);
    chk(rd_first_vld == ef_v, "R3", "first_vld", 32'(rd_first_vld), 32'(ef_v));
    chk(rd_second_vld == es_v, "R3", "second_vld", 32'(rd_second_vld), 32'(es_v));
    if (ef_v) chk(rd_first == ef_d, ef_t, "first beat", 32'(rd_first), 32'(ef_d));
    if (es_v) chk(rd_second == es_d, es_t, "second beat", 32'(rd_second), 32'(es_d));
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b1, a, '0, '0, '1, '1, tag);
  endtask
  task automatic wr(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                    input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    step(1'b0, 1'b0, a, d0, d1, m0, m1, "R4");
  endtask
  task automatic idle();
    step(1'b1, 1'b1, 0, '0, '0, '1, '1, "R1");
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 101 + 5) ^ (k << 9));
  endfunction

  task automatic do_reset();
    ld_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk(!rd_first_vld && !rd_second_vld, "R7", "valids in reset",
        32'({rd_first_vld, rd_second_vld}), 32'h0);
    p_vld = 1'b0;
    pa_v = 1'b0; pb_v = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!rd_first_vld && !rd_second_vld, "R7", "valids held in reset",
        32'({rd_first_vld, rd_second_vld}), 32'h0);
    rst_n = 1'b1;
    idle(); idle(); idle();
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ld_n = 1'b1; rw_n = 1'b1; addr = '0;
    wd_rise = '0; wd_fall = '0; wm_rise_n = '1; wm_fall_n = '1;
    p_vld = 1'b0; p_row = 0; pa_v = 1'b0; pb_v = 1'b0;
    pa_t = "R3"; pb_t = "R3";
    for (int i = 0; i < WORDS; i++) rmem[i] = '0;
    @(negedge clk);
    do_reset();

    // R4/R2: fill array with even start, then overwrite half with odd start
    for (int r = 0; r < WORDS / 2; r++) wr(2 * r, pat(2 * r, 1), pat(2 * r + 1, 1), '0, '0);
    for (int r = 0; r < WORDS / 2; r += 2) wr(2 * r + 1, pat(r, 2), pat(r, 3), '0, '0);
    // R2/R3: back-to-back reads of every start address
    for (int a = 0; a < WORDS; a++) rd(a, "R2");
    idle();

    // R5: read right after write, same row both orders, other row via array
    wr(2, 18'h15a5a, 18'h2c3c3, '0, '0);
    rd(3, "R5");
    rd(2, "R5");
    rd(9, "R5");
    idle();

    // R1: idle slot with write-looking inputs must change nothing
    step(1'b1, 1'b0, 2, 18'h3ffff, 18'h3ffff, '0, '0, "R1");
    step(1'b1, 1'b0, 9, 18'h00001, 18'h00002, '0, '0, "R1");
    rd(2, "R1");
    rd(9, "R1");
    idle();

    // R6: every mask pairing, read merged while pending then after commit
    for (int m0 = 0; m0 < 4; m0++)
      for (int m1 = 0; m1 < 4; m1++) begin
        wr(5, pat(m0, m1 + 7), pat(m1, m0 + 11), NL'(m0), NL'(m1));
        rd(5, "R6");
        rd(4, "R6");
        idle();
      end
    wr(12, 18'h01234, 18'h04321, '0, '0);
    rd(5, "R6");
    rd(4, "R6");
    idle();

    // R8: read, one idle, then write; read-back covers acceptance
    rd(7, "R8");
    idle();
    wr(7, 18'h0beef, 18'h0cafe, '0, '0);
    rd(7, "R8");
    idle();

    // R4/R7: pending write dropped by reset
    wr(6, 18'h11111, 18'h22222, '0, '0);
    wr(12, 18'h33333, 18'h00444, '0, '0);
    wr(6, 18'h05555, 18'h06666, '0, '0);
    rd(6, "R4");
    idle(); idle();
    do_reset();
    rd(6, "R7");
    rd(7, "R7");
    rd(12, "R4");
    idle(); idle(); idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule